// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block is the 8-bit status register of a serial communication port. It collects event pulses from the transmit and receive datapaths into sticky flags. Software reads those flags over a simple register bus at any time. The block also raises three interrupt requests from the flags. The shift registers, baud generation and framing logic live elsewhere; here they are reduced to one-cycle event strobes.

Software acknowledges a flag with a two-step handshake. It must first read the register while the flag is 1. A later write of 0 to that bit then clears the flag. Writing 1 to a flag never changes it.

When transmission is disabled, the transmit-empty flag is held set. A DMA write into the transmit data register clears that flag without the software handshake. A low-power entry strobe puts the register back to its reset contents.

Top module: `ser_stat_reg`

Bit map (the bus layout, MSB first):

| Bit | Meaning |
|-----|---------|
| 7 | tx-empty |
| 6 | rx-full |
| 5 | overrun |
| 4 | framing error |
| 3 | parity error |
| 2 | tx-end |
| 1 | received multiprocessor bit |
| 0 | multiprocessor bit to send |

## Requirements
- R1: After reset, or one cycle after `lowpwr_i` is high, `flags_o` is 0x84, every read arm is cancelled, and bit 0 is 0. Bits 7 and 2 are 1 in that value; all other bits are 0.
- R2: A bus write of 1 to any of bits 7..3 never sets or changes that bit.
- R3: A bus write of 0 to one of bits 7..3 leaves the flag unchanged unless a bus read has seen that flag as 1. The read must come after the flag was last cleared or re-armed.
- R4: A bus write of 0 to an armed flag among bits 7..3 clears it in the cycle after the write.
- R5: A flag's arm is consumed by any write of 0 to that bit, whether or not the clear took effect. It is also dropped whenever the flag is 0. A new clear needs a new read.
- R6: A hardware set event in the same cycle as a software or DMA clear of the same flag leaves the flag at 1.
- R7: Bit 7 is set one cycle after `ev_tx_moved_i`. It is held at 1 in every cycle that follows a cycle with `tx_en_i` low.
- R8: A pulse on `dma_tx_wr_i` clears bit 7 on the next cycle. No prior read is needed.
- R9: Bit 2 is set one cycle after `ev_tx_done_i`. It clears in the same cycle that bit 7 is cleared. Bus writes to it are ignored.
- R10: On `ev_rx_loaded_i`, bit 6 is set and bit 1 takes the value of `ev_rx_mpb_i`. Bus writes to bit 1 are ignored.
- R11: Bit 0 is a plain read/write bit, loaded from `bus_wdata_i[0]` on each bus write.
- R12: `irq_txe_o` equals bit 7. `irq_rxf_o` equals bit 6. `irq_err_o` is the OR of bits 5, 4 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lowpwr_i | input | 1 | Standby or module-stop entry; forces the reset contents |
| bus_rd_i | input | 1 | Bus read strobe (arms flags seen as 1) |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data |
| tx_en_i | input | 1 | Transmit enable control bit |
| ev_tx_moved_i | input | 1 | Transmit buffer moved into the shift register |
| ev_tx_done_i | input | 1 | Transmission complete |
| dma_tx_wr_i | input | 1 | DMA write into the transmit data register |
| ev_rx_loaded_i | input | 1 | Receive buffer loaded |
| ev_rx_mpb_i | input | 1 | Received multiprocessor bit, valid with ev_rx_loaded_i |
| ev_overrun_i | input | 1 | Overrun error event |
| ev_frame_err_i | input | 1 | Framing error event |
| ev_parity_err_i | input | 1 | Parity error event |
| flags_o | output | 8 | Current flag state |
| irq_txe_o | output | 1 | Transmit-empty interrupt request |
| irq_rxf_o | output | 1 | Receive-full interrupt request |
| irq_err_o | output | 1 | Error interrupt request |

## Verification
The hardest state to reach is the arm bit of each flag, because it never appears at the ports. The stimulus therefore proves it indirectly, through ordered sequences: a write of 0 with no read, a write after a read, a second write reusing a consumed arm, and a clear colliding with a set event in the same cycle. A low-power entry after a read shows that the arm has been dropped. Each step queues the expected flag and interrupt word, and a monitor compares it just after the following clock edge.

// File: rtl/ser_stat_pkg.sv
package ser_stat_pkg;
  localparam int REG_W     = 8;
  localparam int STICKY_LO = 3;
  localparam int STICKY_HI = 7;
  localparam int N_STICKY  = STICKY_HI - STICKY_LO + 1;
  localparam int B_TXE     = 7;
  localparam int B_RXF     = 6;
  localparam int B_OVR     = 5;
  localparam int B_FRM     = 4;
  localparam int B_PAR     = 3;
  localparam int B_TEND    = 2;
  localparam int B_MPRX    = 1;
  localparam int B_MPTX    = 0;
  localparam logic [REG_W-1:0] RESET_VAL = 8'h84;
endpackage

// File: rtl/sr_sticky_flag.sv
module sr_sticky_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic set_i,
  input  logic hold_i,
  input  logic hw_clr_i,
  output logic flag_o,
  output logic clr_o
);
  logic flag_q, flag_n;
  logic arm_q, arm_n;
  logic sw_clr;

  always_comb begin
    sw_clr = wr_i & ~wbit_i & arm_q;
    flag_n = flag_q;
    if (sw_clr || hw_clr_i) flag_n = 1'b0;
    if (set_i || hold_i)    flag_n = 1'b1;
    if (init_i)             flag_n = RST_VAL;

    arm_n = arm_q;
    if (rd_i && flag_q) arm_n = 1'b1;
    if (init_i || !flag_n || (wr_i && !wbit_i)) arm_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      arm_q  <= arm_n;
    end
  end

  assign flag_o = flag_q;
  assign clr_o  = flag_q & ~flag_n;
endmodule

// File: rtl/sr_aux_bits.sv
module sr_aux_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic tx_done_i,
  input  logic txe_clr_i,
  input  logic rx_load_i,
  input  logic rx_mpb_i,
  input  logic wr_i,
  input  logic wbit0_i,
  output logic tend_o,
  output logic mprx_o,
  output logic mptx_o
);
  logic tend_q, tend_n;
  logic mprx_q, mprx_n;
  logic mptx_q, mptx_n;

  always_comb begin
    tend_n = tend_q;
    if (txe_clr_i) tend_n = 1'b0;
    if (tx_done_i) tend_n = 1'b1;

    mprx_n = rx_load_i ? rx_mpb_i : mprx_q;
    mptx_n = wr_i ? wbit0_i : mptx_q;

    if (init_i) begin
      tend_n = 1'b1;
      mprx_n = 1'b0;
      mptx_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tend_q <= 1'b1;
      mprx_q <= 1'b0;
      mptx_q <= 1'b0;
    end else begin
      tend_q <= tend_n;
      mprx_q <= mprx_n;
      mptx_q <= mptx_n;
    end
  end

  assign tend_o = tend_q;
  assign mprx_o = mprx_q;
  assign mptx_o = mptx_q;
endmodule

// File: rtl/ser_stat_reg.sv
module ser_stat_reg
  import ser_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lowpwr_i,
  input  logic             bus_rd_i,
  input  logic             bus_wr_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  input  logic             tx_en_i,
  input  logic             ev_tx_moved_i,
  input  logic             ev_tx_done_i,
  input  logic             dma_tx_wr_i,
  input  logic             ev_rx_loaded_i,
  input  logic             ev_rx_mpb_i,
  input  logic             ev_overrun_i,
  input  logic             ev_frame_err_i,
  input  logic             ev_parity_err_i,
  output logic [REG_W-1:0] flags_o,
  output logic             irq_txe_o,
  output logic             irq_rxf_o,
  output logic             irq_err_o
);
  logic [N_STICKY-1:0] set_v, hold_v, hwclr_v, flag_v, clr_v;
  logic                tend, mprx, mptx;
  logic                unused_wbits;

  assign unused_wbits = ^bus_wdata_i[B_TEND:B_MPRX];

  // set events per sticky bit, index 0 is bit STICKY_LO
  assign set_v  = {ev_tx_moved_i, ev_rx_loaded_i, ev_overrun_i,
                   ev_frame_err_i, ev_parity_err_i};
  assign hold_v = {~tx_en_i, {(N_STICKY-1){1'b0}}};
  assign hwclr_v = {dma_tx_wr_i, {(N_STICKY-1){1'b0}}};

  for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
    sr_sticky_flag #(.RST_VAL(RESET_VAL[STICKY_LO+i])) u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .init_i   (lowpwr_i),
      .rd_i     (bus_rd_i),
      .wr_i     (bus_wr_i),
      .wbit_i   (bus_wdata_i[STICKY_LO+i]),
      .set_i    (set_v[i]),
      .hold_i   (hold_v[i]),
      .hw_clr_i (hwclr_v[i]),
      .flag_o   (flag_v[i]),
      .clr_o    (clr_v[i])
    );
  end

  sr_aux_bits u_aux (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_i    (lowpwr_i),
    .tx_done_i (ev_tx_done_i),
    .txe_clr_i (clr_v[B_TXE-STICKY_LO]),
    .rx_load_i (ev_rx_loaded_i),
    .rx_mpb_i  (ev_rx_mpb_i),
    .wr_i      (bus_wr_i),
    .wbit0_i   (bus_wdata_i[B_MPTX]),
    .tend_o    (tend),
    .mprx_o    (mprx),
    .mptx_o    (mptx)
  );

  assign flags_o     = {flag_v, tend, mprx, mptx};
  assign bus_rdata_o = flags_o;
  assign irq_txe_o   = flags_o[B_TXE];
  assign irq_rxf_o   = flags_o[B_RXF];
  assign irq_err_o   = |flags_o[B_OVR:B_PAR];
endmodule

// File: rtl/ser_stat_chk.sv
module ser_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lowpwr_i,
  input logic       bus_wr_i,
  input logic [7:0] bus_wdata_i,
  input logic       tx_en_i,
  input logic       ev_tx_done_i,
  input logic       ev_rx_loaded_i,
  input logic       ev_rx_mpb_i,
  input logic       ev_overrun_i,
  input logic [7:0] flags_o
);
  // R1
  lowpwr_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lowpwr_i |=> (flags_o == 8'h84));

  // R2
  write_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_wdata_i[5] && !flags_o[5] && !ev_overrun_i && !lowpwr_i)
    |=> !flags_o[5]);

  // R6
  rx_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_loaded_i && !lowpwr_i) |=> flags_o[6]);

  // R7
  txe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_i |=> flags_o[7]);

  // R9
  tend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[2]) |-> ($past(ev_tx_done_i) || $past(lowpwr_i)));

  // R10
  mprx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_loaded_i && !lowpwr_i) |=> (flags_o[1] == $past(ev_rx_mpb_i)));

  // R11
  mptx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && !lowpwr_i) |=> (flags_o[0] == $past(bus_wdata_i[0])));
endmodule

bind ser_stat_reg ser_stat_chk u_chk (.*);

// File: tb/sim_ser_stat_reg.sv
`timescale 1ns/1ps
module sim_ser_stat_reg;
  logic       clk, rst_n, lowpwr, rd, wr, tx_en;
  logic [7:0] wdata;
  logic       tx_moved, tx_done, dma_wr, rx_loaded, rx_mpb, ovr, frm, par;
  logic [7:0] rdata, flags;
  logic       irq_txe, irq_rxf, irq_err;

  int  n_chk, n_fail;
  bit  done;
  logic [10:0] exp_q[$];
  string       tag_q[$];

  ser_stat_reg u0 (
    .clk(clk), .rst_n(rst_n), .lowpwr_i(lowpwr),
    .bus_rd_i(rd), .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .tx_en_i(tx_en), .ev_tx_moved_i(tx_moved), .ev_tx_done_i(tx_done),
    .dma_tx_wr_i(dma_wr), .ev_rx_loaded_i(rx_loaded), .ev_rx_mpb_i(rx_mpb),
    .ev_overrun_i(ovr), .ev_frame_err_i(frm), .ev_parity_err_i(par),
    .flags_o(flags), .irq_txe_o(irq_txe), .irq_rxf_o(irq_rxf), .irq_err_o(irq_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // R12 expected interrupt requests derived from the flag word
  function automatic logic [10:0] with_irq(logic [7:0] f);
    return {f[7], f[6], |f[5:3], f};
  endfunction

  task automatic clear_strobes();
    lowpwr = 0; rd = 0; wr = 0; wdata = 8'h00; tx_moved = 0; tx_done = 0;
    dma_wr = 0; rx_loaded = 0; rx_mpb = 0; ovr = 0; frm = 0; par = 0;
  endtask

  // strobes are set by the caller at a falling edge; this queues the
  // expected result of the next rising edge and ends the cycle
  task automatic step(logic [7:0] exp_flags, string tag);
    exp_q.push_back(with_irq(exp_flags));
    tag_q.push_back(tag);
    @(negedge clk);
    clear_strobes();
  endtask

  task automatic bus_write(logic [7:0] d, logic [7:0] e, string tag);
    wr = 1; wdata = d; step(e, tag);
  endtask

  task automatic bus_read(logic [7:0] e, string tag);
    rd = 1; step(e, tag);
    n_chk++;
    if (rdata !== e) begin
      n_fail++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, e);
    end
  endtask

  // monitor: compare queued expectation right after each rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [10:0] e;
      logic [10:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {irq_txe, irq_rxf, irq_err, flags};
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    clear_strobes();
    tx_en = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(8'h84, "R1 reset value");
    tx_en = 1;
    step(8'h84, "R1 idle");
    rx_loaded = 1; rx_mpb = 1; step(8'hC6, "R10 rx load mpb=1");
    bus_write(8'h00, 8'hC6, "R3 write0 unarmed, R9 R10 ro bits");
    bus_write(8'hFF, 8'hC7, "R2 write1 no effect, R11 bit0");
    bus_read(8'hC7, "R3 read arms");
    bus_write(8'hBF, 8'h87, "R4 armed clear rx-full");
    rx_loaded = 1; rx_mpb = 0; step(8'hC5, "R10 rx load mpb=0");
    bus_write(8'hBF, 8'hC5, "R5 stale arm no clear");
    bus_read(8'hC5, "R5 re-read");
    bus_write(8'hBF, 8'hC5, "R6 clear vs set"); // set strobe added below
    bus_write(8'hBF, 8'hC5, "R5 arm consumed by write0");
    ovr = 1; frm = 1; par = 1; step(8'hFD, "R12 error flags set");
    bus_read(8'hFD, "R4 read errors");
    bus_write(8'hE1, 8'hE5, "R4 clear framing+parity, R12 err held");
    bus_read(8'hE5, "R4 read overrun");
    bus_write(8'hDF, 8'hC5, "R12 err drops");
    dma_wr = 1; step(8'h41, "R8 dma clear, R9 tend clears");
    tx_moved = 1; step(8'hC1, "R7 tx moved sets");
    tx_done = 1; step(8'hC5, "R9 tx done sets");
    bus_read(8'hC5, "R4 read txe");
    bus_write(8'h45, 8'h41, "R4 R9 sw clear txe and tend");
    tx_en = 0; step(8'hC1, "R7 hold while disabled");
    dma_wr = 1; step(8'hC1, "R7 hold beats dma");
    tx_en = 1;
    bus_read(8'hC1, "R1 read before lowpwr");
    lowpwr = 1; step(8'h84, "R1 lowpwr forces");
    bus_write(8'h04, 8'h84, "R1 arm dropped by lowpwr");
    dma_wr = 1; tx_moved = 1; step(8'h84, "R6 dma clear vs tx moved");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // the R6 collision step needs a set strobe in the same cycle as the write
  initial begin
    wait (rst_n);
    forever begin
      @(negedge clk);
      #1;
      if (tag_q.size() > 0 && tag_q[tag_q.size()-1] == "R6 clear vs set" && wr) begin
        rx_loaded = 1; rx_mpb = 0;
      end
    end
  end
endmodule